// File: doc/BRIEF.md
# Locked Pseudo-LRU Victim Selection and Write-Back Drain

This block sits beside the tag and data arrays of an 8-way set-associative data cache with 16 sets. When the cache must bring in a line, it presents the indexed set's per-way valid and lock bits. The block then names the way to fill. If any way is invalid, that way is used and nothing is evicted. If the set is full, a binary-tree pseudo-LRU walk proposes a victim. A locked way is never taken: the lowest-numbered unlocked way is used instead. When every way is locked, the block reports that it has no victim and allocates nothing. Hits and fills both steer the tree of their set away from the way just used.

An evicted line goes into a one-line write-back buffer. The line is read from the data array one fetch set per cycle; a line holds 16 fetch sets of 16 bytes each. The buffer then writes only the fetch sets marked dirty to memory, one fetch set per beat, and groups those beats into bursts of a programmable length. A victim with no dirty fetch set is dropped without any traffic. While the buffer holds a line, any allocation that would evict is stalled. An allocation that only fills an invalid way still proceeds.

Top module: `victim_evict_unit`

## Requirements
- R1: If any bit of `way_valid` is 0, `alloc_way` is the lowest-numbered invalid way and `alloc_evict` is 0, whatever the lock bits are.
- R2: In a full set, the victim comes from a 3-level tree walk. Starting at the root, a node bit of 0 selects the lower-numbered half. After reset every bit is 0, so the victim is way 0.
- R3: When `hit_en` is high, or when an allocation is acknowledged, each of the three node bits on the path to that way in that set is set to the inverse of the branch taken. Other sets are unchanged.
- R4: If the tree's choice is locked, the lowest-numbered unlocked way is used. If all eight ways are locked in a full set, `alloc_none` is 1 and `alloc_ack` is 0.
- R5: `alloc_ack` is 1 for a request unless `alloc_none` is 1, or an eviction is needed while the write-back buffer is occupied. Fills of invalid ways are acknowledged even while the buffer is occupied.
- R6: After an evicting acknowledge with a nonzero `vic_dirty`, the buffer reads fetch sets 0 to 15 in ascending order, one per cycle, on `rd_en`/`rd_idx`. It takes `rd_data` in the cycle after each read.
- R7: The dirty fetch sets are written in ascending index order. Each beat carries address {line, index, 4'b0000} and the data that was read for that index. Clean fetch sets are not written.
- R8: `mem_last` marks the end of a burst. That is the beat that completes `1 << burst_code` beats, or the final dirty beat. Codes 4 to 7 all mean 16.
- R9: An evicting acknowledge with `vic_dirty` equal to 0 produces no read and no memory beat, and leaves the buffer free.
- R10: After reset, `rd_en`, `mem_valid` and `alloc_ack` (with no request) are 0.
- R11: While `mem_valid` is 1 and `mem_ready` is 0, the beat's address and data are held unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_en | input | 1 | A cache hit updates the pseudo-LRU tree |
| hit_set | input | 4 | Set of the hit |
| hit_way | input | 3 | Way of the hit |
| alloc_req | input | 1 | Allocation request for `alloc_set` |
| alloc_set | input | 4 | Indexed set |
| way_valid | input | 8 | Valid bit of each way of that set |
| way_lock | input | 8 | Lock bit of each way of that set |
| vic_line | input | 24 | Line address of the way named by `alloc_way` |
| vic_dirty | input | 16 | Fetch-set dirty bits of the way named by `alloc_way` |
| burst_code | input | 3 | Burst length, log2 of beats, sampled at eviction |
| alloc_way | output | 3 | Way to fill |
| alloc_evict | output | 1 | The chosen way holds a valid line that is evicted |
| alloc_none | output | 1 | Every way locked in a full set |
| alloc_ack | output | 1 | Allocation accepted this cycle |
| rd_en | output | 1 | Read one fetch set of the victim line |
| rd_set | output | 4 | Set of the victim |
| rd_way | output | 3 | Way of the victim |
| rd_idx | output | 4 | Fetch-set index read |
| rd_data | input | 128 | Fetch-set data, valid the cycle after `rd_en` |
| mem_valid | output | 1 | Memory write beat valid |
| mem_ready | input | 1 | Memory accepts the beat |
| mem_addr | output | 32 | Byte address of the fetch set |
| mem_data | output | 128 | Fetch-set data |
| mem_last | output | 1 | Final beat of a burst |

## Verification
Two situations are hard to reach from the ports. The first is a lock that collides with the tree's choice after the tree has been moved by earlier hits. The bench issues hits to one set so that the walk lands on a known way, and then locks exactly that way. The second is an allocation that must stall while the buffer is still filling or draining. The bench starts an eviction whose drain is slowed by gaps in `mem_ready`. While that eviction is running, it presents both an evicting request and a non-evicting request, and compares the acknowledge of each with the stall rule.

// File: rtl/evd_pkg.sv
package evd_pkg;
    localparam int WAYS     = 8;
    localparam int SETS     = 16;
    localparam int FSETS    = 16;
    localparam int FS_BYTES = 16;
    localparam int FS_BITS  = FS_BYTES * 8;
    localparam int ADDR_W   = 32;
    localparam int BL_W     = 3;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_FILL  = 2'd1,
        PH_DRAIN = 2'd2
    } wb_phase_t;
endpackage

// File: rtl/plru_tree.sv
module plru_tree #(
    parameter int WAYS  = evd_pkg::WAYS,
    parameter int SETS  = evd_pkg::SETS,
    localparam int WAY_W = $clog2(WAYS),
    localparam int SET_W = $clog2(SETS),
    localparam int NODES = WAYS - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_en,
    input  logic [SET_W-1:0] hit_set,
    input  logic [WAY_W-1:0] hit_way,
    input  logic             fill_en,
    input  logic [SET_W-1:0] fill_set,
    input  logic [WAY_W-1:0] fill_way,
    input  logic [SET_W-1:0] look_set,
    output logic [WAY_W-1:0] tree_way
);
    typedef struct packed {
        logic [SETS-1:0][NODES-1:0] bits;
    } tree_st_t;

    tree_st_t st_d, st_q;

    function automatic logic [NODES-1:0] steer_away(input logic [NODES-1:0] b,
                                                     input logic [WAY_W-1:0] w);
        logic [NODES-1:0] r;
        int node;
        r    = b;
        node = 0;
        for (int lvl = 0; lvl < WAY_W; lvl++) begin
            r[node] = ~w[WAY_W-1-lvl];
            node    = 2 * node + 1 + int'(w[WAY_W-1-lvl]);
        end
        return r;
    endfunction

    always_comb begin
        logic [NODES-1:0] b;
        int node;
        b        = st_q.bits[look_set];
        node     = 0;
        tree_way = '0;
        for (int lvl = 0; lvl < WAY_W; lvl++) begin
            tree_way = {tree_way[WAY_W-2:0], b[node]};
            node     = 2 * node + 1 + int'(b[node]);
        end
    end

    always_comb begin
        st_d = st_q;
        if (hit_en)
            st_d.bits[hit_set] = steer_away(st_d.bits[hit_set], hit_way);
        if (fill_en)
            st_d.bits[fill_set] = steer_away(st_d.bits[fill_set], fill_way);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/victim_sel.sv
module victim_sel #(
    parameter int WAYS  = evd_pkg::WAYS,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]  valid,
    input  logic [WAYS-1:0]  lock,
    input  logic [WAY_W-1:0] tree_way,
    output logic [WAY_W-1:0] way,
    output logic             evict,
    output logic             none
);
    always_comb begin
        way   = tree_way;
        evict = 1'b0;
        none  = 1'b0;
        if (!(&valid)) begin
            for (int i = WAYS - 1; i >= 0; i--)
                if (!valid[i]) way = WAY_W'(i);
        end else begin
            evict = 1'b1;
            if (lock[tree_way]) begin
                none = &lock;
                way  = '0;
                for (int i = WAYS - 1; i >= 0; i--)
                    if (!lock[i]) way = WAY_W'(i);
            end
        end
    end
endmodule

// File: rtl/wb_buffer.sv
module wb_buffer #(
    parameter int FSETS    = evd_pkg::FSETS,
    parameter int FS_BITS  = evd_pkg::FS_BITS,
    parameter int FS_BYTES = evd_pkg::FS_BYTES,
    parameter int ADDR_W   = evd_pkg::ADDR_W,
    parameter int SETS     = evd_pkg::SETS,
    parameter int WAYS     = evd_pkg::WAYS,
    parameter int BL_W     = evd_pkg::BL_W,
    localparam int FS_W    = $clog2(FSETS),
    localparam int OFF_W   = $clog2(FS_BYTES),
    localparam int LINE_W  = ADDR_W - FS_W - OFF_W,
    localparam int SET_W   = $clog2(SETS),
    localparam int WAY_W   = $clog2(WAYS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [SET_W-1:0]   start_set,
    input  logic [WAY_W-1:0]   start_way,
    input  logic [LINE_W-1:0]  start_line,
    input  logic [FSETS-1:0]   start_dirty,
    input  logic [BL_W-1:0]    start_blcode,
    output logic               busy,
    output logic               rd_en,
    output logic [SET_W-1:0]   rd_set,
    output logic [WAY_W-1:0]   rd_way,
    output logic [FS_W-1:0]    rd_idx,
    input  logic [FS_BITS-1:0] rd_data,
    output logic               mem_valid,
    input  logic               mem_ready,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [FS_BITS-1:0] mem_data,
    output logic               mem_last
);
    import evd_pkg::*;

    typedef struct packed {
        wb_phase_t                      ph;
        logic [FS_W:0]                  iss;
        logic                           cap_v;
        logic [FS_W-1:0]                cap_idx;
        logic [FSETS-1:0][FS_BITS-1:0]  data;
        logic [FSETS-1:0]               pend;
        logic [LINE_W-1:0]              line;
        logic [SET_W-1:0]               set;
        logic [WAY_W-1:0]               way;
        logic [FS_W:0]                  blen;
        logic [FS_W:0]                  beat;
    } wb_st_t;

    wb_st_t st_d, st_q;
    logic [FS_W-1:0] cur;
    logic            final_beat;

    always_comb begin
        cur = '0;
        for (int i = FSETS - 1; i >= 0; i--)
            if (st_q.pend[i]) cur = FS_W'(i);
        final_beat = ((st_q.pend & (st_q.pend - 1'b1)) == '0);
    end

    assign busy      = (st_q.ph != PH_IDLE);
    assign rd_en     = (st_q.ph == PH_FILL) && (st_q.iss < (FS_W+1)'(FSETS));
    assign rd_idx    = st_q.iss[FS_W-1:0];
    assign rd_set    = st_q.set;
    assign rd_way    = st_q.way;
    assign mem_valid = (st_q.ph == PH_DRAIN);
    assign mem_addr  = {st_q.line, cur, {OFF_W{1'b0}}};
    assign mem_data  = st_q.data[cur];
    assign mem_last  = (st_q.beat == st_q.blen - 1'b1) || final_beat;

    always_comb begin
        st_d = st_q;
        unique case (st_q.ph)
            PH_IDLE: begin
                if (start && (|start_dirty)) begin
                    st_d.ph    = PH_FILL;
                    st_d.iss   = '0;
                    st_d.cap_v = 1'b0;
                    st_d.pend  = start_dirty;
                    st_d.line  = start_line;
                    st_d.set   = start_set;
                    st_d.way   = start_way;
                    st_d.beat  = '0;
                    if (int'(start_blcode) >= FS_W) st_d.blen = (FS_W+1)'(FSETS);
                    else st_d.blen = {{FS_W{1'b0}}, 1'b1} << start_blcode;
                end
            end
            PH_FILL: begin
                st_d.cap_v   = rd_en;
                st_d.cap_idx = rd_idx;
                if (rd_en) st_d.iss = st_q.iss + 1'b1;
                if (st_q.cap_v) begin
                    st_d.data[st_q.cap_idx] = rd_data;
                    if (st_q.cap_idx == FS_W'(FSETS - 1)) st_d.ph = PH_DRAIN;
                end
            end
            PH_DRAIN: begin
                if (mem_ready) begin
                    st_d.pend[cur] = 1'b0;
                    st_d.beat      = mem_last ? '0 : st_q.beat + 1'b1;
                    if (final_beat) st_d.ph = PH_IDLE;
                end
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_beat_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data));

    assert_read_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && $past(rd_en) |-> rd_idx == $past(rd_idx) + 1'b1);

    assert_no_read_while_drain_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> !rd_en);
endmodule

// File: rtl/victim_evict_unit.sv
module victim_evict_unit #(
    parameter int WAYS     = evd_pkg::WAYS,
    parameter int SETS     = evd_pkg::SETS,
    parameter int FSETS    = evd_pkg::FSETS,
    parameter int FS_BYTES = evd_pkg::FS_BYTES,
    parameter int FS_BITS  = evd_pkg::FS_BITS,
    parameter int ADDR_W   = evd_pkg::ADDR_W,
    parameter int BL_W     = evd_pkg::BL_W,
    localparam int WAY_W   = $clog2(WAYS),
    localparam int SET_W   = $clog2(SETS),
    localparam int FS_W    = $clog2(FSETS),
    localparam int LINE_W  = ADDR_W - FS_W - $clog2(FS_BYTES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hit_en,
    input  logic [SET_W-1:0]   hit_set,
    input  logic [WAY_W-1:0]   hit_way,
    input  logic               alloc_req,
    input  logic [SET_W-1:0]   alloc_set,
    input  logic [WAYS-1:0]    way_valid,
    input  logic [WAYS-1:0]    way_lock,
    input  logic [LINE_W-1:0]  vic_line,
    input  logic [FSETS-1:0]   vic_dirty,
    input  logic [BL_W-1:0]    burst_code,
    output logic [WAY_W-1:0]   alloc_way,
    output logic               alloc_evict,
    output logic               alloc_none,
    output logic               alloc_ack,
    output logic               rd_en,
    output logic [SET_W-1:0]   rd_set,
    output logic [WAY_W-1:0]   rd_way,
    output logic [FS_W-1:0]    rd_idx,
    input  logic [FS_BITS-1:0] rd_data,
    output logic               mem_valid,
    input  logic               mem_ready,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [FS_BITS-1:0] mem_data,
    output logic               mem_last
);
    logic [WAY_W-1:0] tree_way;
    logic             buf_busy;
    logic             evict_go;

    plru_tree #(.WAYS(WAYS), .SETS(SETS)) u_tree (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit_en   (hit_en),
        .hit_set  (hit_set),
        .hit_way  (hit_way),
        .fill_en  (alloc_ack),
        .fill_set (alloc_set),
        .fill_way (alloc_way),
        .look_set (alloc_set),
        .tree_way (tree_way)
    );

    victim_sel #(.WAYS(WAYS)) u_sel (
        .valid    (way_valid),
        .lock     (way_lock),
        .tree_way (tree_way),
        .way      (alloc_way),
        .evict    (alloc_evict),
        .none     (alloc_none)
    );

    assign alloc_ack = alloc_req && !alloc_none && (!alloc_evict || !buf_busy);
    assign evict_go  = alloc_ack && alloc_evict;

    wb_buffer #(
        .FSETS(FSETS), .FS_BITS(FS_BITS), .FS_BYTES(FS_BYTES), .ADDR_W(ADDR_W),
        .SETS(SETS), .WAYS(WAYS), .BL_W(BL_W)
    ) u_wbb (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (evict_go),
        .start_set    (alloc_set),
        .start_way    (alloc_way),
        .start_line   (vic_line),
        .start_dirty  (vic_dirty),
        .start_blcode (burst_code),
        .busy         (buf_busy),
        .rd_en        (rd_en),
        .rd_set       (rd_set),
        .rd_way       (rd_way),
        .rd_idx       (rd_idx),
        .rd_data      (rd_data),
        .mem_valid    (mem_valid),
        .mem_ready    (mem_ready),
        .mem_addr     (mem_addr),
        .mem_data     (mem_data),
        .mem_last     (mem_last)
    );

    assert_locked_never_victim_R4: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_req && alloc_evict && !alloc_none |-> !way_lock[alloc_way]);

    assert_no_ack_without_way_R4: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_none |-> !alloc_ack);

    assert_invalid_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_req && !(&way_valid) |-> !alloc_evict && !way_valid[alloc_way]);

    assert_evict_stalls_R5: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_ack && alloc_evict |-> !buf_busy);
endmodule

// File: tb/victim_evict_unit_bench.sv
module victim_evict_unit_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         hit_en = 1'b0;
    logic [3:0]   hit_set = '0;
    logic [2:0]   hit_way = '0;
    logic         alloc_req = 1'b0;
    logic [3:0]   alloc_set = '0;
    logic [7:0]   way_valid = '0;
    logic [7:0]   way_lock = '0;
    logic [23:0]  vic_line = '0;
    logic [15:0]  vic_dirty = '0;
    logic [2:0]   burst_code = '0;
    logic [2:0]   alloc_way;
    logic         alloc_evict, alloc_none, alloc_ack;
    logic         rd_en;
    logic [3:0]   rd_set;
    logic [2:0]   rd_way;
    logic [3:0]   rd_idx;
    logic [127:0] rd_data = '0;
    logic         mem_valid;
    logic         mem_ready = 1'b1;
    logic [31:0]  mem_addr;
    logic [127:0] mem_data;
    logic         mem_last;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    bit gaps = 1'b0;
    int gcnt = 0;
    int nb = 0;
    int n_rd = 0;
    int n_mv = 0;
    logic [3:0]   rd_next = '0;
    logic [31:0]  b_addr [32];
    logic [127:0] b_data [32];
    logic         b_last [32];
    logic         stall_q = 1'b0;
    logic [31:0]  stall_addr = '0;

    victim_evict_unit u_victim_evict_unit (.*);

    always #4 clk = ~clk;

    // Table: valid, lock, expected way, expected evict, expected none (tree at reset state)
    localparam logic [20:0] VEC [8] = '{
        {8'hFF, 8'h00, 3'd0, 1'b1, 1'b0},
        {8'hFF, 8'h01, 3'd1, 1'b1, 1'b0},
        {8'hFF, 8'h0F, 3'd4, 1'b1, 1'b0},
        {8'hFF, 8'hFF, 3'd0, 1'b1, 1'b1},
        {8'hFB, 8'h00, 3'd2, 1'b0, 1'b0},
        {8'h00, 8'h00, 3'd0, 1'b0, 1'b0},
        {8'h7F, 8'hFF, 3'd7, 1'b0, 1'b0},
        {8'hFF, 8'hFE, 3'd0, 1'b1, 1'b0}
    };

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [127:0] pat(input logic [3:0] s, input logic [2:0] w,
                                         input logic [3:0] i);
        logic [31:0] x;
        x = {16'hC0DE, 4'h0, s, 1'b0, w, i};
        return {4{x}};
    endfunction

    always @(posedge clk) if (rd_en) rd_data <= pat(rd_set, rd_way, rd_idx);

    always @(negedge clk) begin
        mem_ready = gaps ? ((gcnt % 3) != 1) : 1'b1;
        gcnt++;
    end

    always @(posedge clk) begin
        if (rst_n) begin
            if (rd_en) begin
                n_rd++;
                chk("R6 read index order", 128'(rd_idx), 128'(rd_next));
                rd_next = rd_idx + 4'd1;
            end
            if (mem_valid) n_mv++;
            if (stall_q) begin
                chk("R11 held valid", 128'(mem_valid), 128'(1));
                chk("R11 held address", 128'(mem_addr), 128'(stall_addr));
            end
            stall_q    = mem_valid && !mem_ready;
            stall_addr = mem_addr;
            if (mem_valid && mem_ready && nb < 32) begin
                b_addr[nb] = mem_addr;
                b_data[nb] = mem_data;
                b_last[nb] = mem_last;
                nb++;
            end
        end
    end

    // Present a request at the negedge, sample 2 ns later; hold it across the edge if asked.
    task automatic present(input logic [3:0] s, input logic [7:0] v, input logic [7:0] l,
                           input logic [23:0] line, input logic [15:0] d, input logic [2:0] bc,
                           input bit hold,
                           output logic [2:0] w, output logic ev, output logic no,
                           output logic ak);
        @(negedge clk);
        alloc_req = 1'b1; alloc_set = s; way_valid = v; way_lock = l;
        vic_line = line; vic_dirty = d; burst_code = bc;
        #2;
        w = alloc_way; ev = alloc_evict; no = alloc_none; ak = alloc_ack;
        if (hold) @(posedge clk);
        #1 alloc_req = 1'b0;
    endtask

    task automatic hit(input logic [3:0] s, input logic [2:0] w);
        @(negedge clk);
        hit_en = 1'b1; hit_set = s; hit_way = w;
        @(posedge clk);
        #1 hit_en = 1'b0;
    endtask

    task automatic check_drain(input string tag, input logic [23:0] line, input logic [3:0] s,
                               input logic [2:0] w, input logic [15:0] d, input logic [2:0] bc);
        int expn;
        int blen;
        int k;
        int n;
        logic lst;
        expn = $countones(d);
        for (int c = 0; c < 600 && nb < expn; c++) @(posedge clk);
        repeat (4) @(posedge clk);
        chk({tag, " R7 beat count"}, 128'(nb), 128'(expn));
        blen = (bc >= 3'd4) ? 16 : (1 << bc);
        k = 0;
        n = 0;
        for (int i = 0; i < 16; i++) begin
            if (d[i] && n < nb) begin
                lst = (k == blen - 1) || ((d >> (i + 1)) == 16'h0);
                chk({tag, " R7 address"}, 128'(b_addr[n]), 128'({line, 4'(i), 4'h0}));
                chk({tag, " R7 data"}, b_data[n], pat(s, w, 4'(i)));
                chk({tag, " R8 last"}, 128'(b_last[n]), 128'(lst));
                k = lst ? 0 : k + 1;
                n++;
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [2:0] w;
        logic ev, no, ak;
        logic [2:0] w1;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #2;
        chk("R10 rd_en after reset", 128'(rd_en), 128'(0));
        chk("R10 mem_valid after reset", 128'(mem_valid), 128'(0));
        chk("R10 alloc_ack idle", 128'(alloc_ack), 128'(0));

        // Table walk: selection with the tree in its reset state (probes are not acknowledged at an edge)
        for (int t = 0; t < 8; t++) begin
            present(4'd1, VEC[t][20:13], VEC[t][12:5], 24'h0, 16'h0, 3'd0, 1'b0, w, ev, no, ak);
            chk($sformatf("R1/R2/R4 table %0d none", t), 128'(no), 128'(VEC[t][0]));
            chk($sformatf("R1/R2/R4 table %0d evict", t), 128'(ev), 128'(VEC[t][1]));
            if (!VEC[t][0]) chk($sformatf("R1/R2/R4 table %0d way", t), 128'(w), 128'(VEC[t][4:2]));
            chk($sformatf("R4/R5 table %0d ack", t), 128'(ak), 128'(!VEC[t][0]));
        end

        // R3: hits steer the tree of set 3 only
        hit(4'd3, 3'd0);
        present(4'd3, 8'hFF, 8'h00, 24'h0, 16'h0, 3'd0, 1'b0, w, ev, no, ak);
        chk("R3 after hit way0", 128'(w), 128'(4));
        hit(4'd3, 3'd4);
        present(4'd3, 8'hFF, 8'h00, 24'h0, 16'h0, 3'd0, 1'b0, w, ev, no, ak);
        chk("R3 after hit way4", 128'(w), 128'(2));
        present(4'd5, 8'hFF, 8'h00, 24'h0, 16'h0, 3'd0, 1'b0, w, ev, no, ak);
        chk("R3 other set untouched", 128'(w), 128'(0));
        present(4'd3, 8'hFF, 8'h04, 24'h0, 16'h0, 3'd0, 1'b0, w, ev, no, ak);
        chk("R4 locked tree choice falls back", 128'(w), 128'(0));

        // Eviction with gaps on mem_ready, 2-beat bursts
        gaps = 1'b1;
        nb = 0;
        present(4'd3, 8'hFF, 8'h00, 24'h5A5A51, 16'h802D, 3'd1, 1'b1, w1, ev, no, ak);
        chk("R2 evict way from moved tree", 128'(w1), 128'(2));
        chk("R5 evict ack when free", 128'(ak), 128'(1));
        present(4'd12, 8'hFF, 8'h00, 24'h0, 16'hFFFF, 3'd0, 1'b0, w, ev, no, ak);
        chk("R5 evict stalled while busy", 128'(ak), 128'(0));
        present(4'd9, 8'hFE, 8'h00, 24'h0, 16'h0, 3'd0, 1'b1, w, ev, no, ak);
        chk("R5 fill acked while busy", 128'(ak), 128'(1));
        chk("R1 fill way", 128'(w), 128'(0));
        check_drain("E1", 24'h5A5A51, 4'd3, w1, 16'h802D, 3'd1);
        gaps = 1'b0;
        present(4'd9, 8'hFF, 8'h00, 24'h0, 16'h0, 3'd0, 1'b0, w, ev, no, ak);
        chk("R3 fill steers tree", 128'(w), 128'(4));

        // Full line, 16-beat burst
        nb = 0;
        present(4'd7, 8'hFF, 8'h00, 24'h123456, 16'hFFFF, 3'd4, 1'b1, w1, ev, no, ak);
        chk("R5 ack E2", 128'(ak), 128'(1));
        check_drain("E2", 24'h123456, 4'd7, w1, 16'hFFFF, 3'd4);

        // Code 7 clamps to 16
        nb = 0;
        present(4'd8, 8'hFF, 8'h00, 24'hFEDCBA, 16'h0F0F, 3'd7, 1'b1, w1, ev, no, ak);
        check_drain("E3 clamp", 24'hFEDCBA, 4'd8, w1, 16'h0F0F, 3'd7);

        // Single-beat bursts
        nb = 0;
        present(4'd10, 8'hFF, 8'h00, 24'h000ABC, 16'h00F1, 3'd0, 1'b1, w1, ev, no, ak);
        check_drain("E4 single", 24'h000ABC, 4'd10, w1, 16'h00F1, 3'd0);

        // R9: clean victim is dropped
        nb = 0; n_rd = 0; n_mv = 0;
        present(4'd11, 8'hFF, 8'h00, 24'h777777, 16'h0000, 3'd2, 1'b1, w, ev, no, ak);
        chk("R9 clean evict acked", 128'(ak), 128'(1));
        repeat (40) @(posedge clk);
        chk("R9 no reads", 128'(n_rd), 128'(0));
        chk("R9 no memory beats", 128'(n_mv), 128'(0));
        present(4'd12, 8'hFF, 8'h00, 24'h0, 16'h0, 3'd0, 1'b0, w, ev, no, ak);
        chk("R9 buffer left free", 128'(ak), 128'(1));

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule